// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It spots the one data dependence that bypassing cannot cover: the instruction in decode reads a register that the load now in execute has yet to fetch from memory. When that happens it holds the program counter and the fetch/decode register for one cycle and sends a no-op into execute in place of the consumer. Instructions further down the pipeline keep moving, so the load reaches its memory stage and the dependence can then be met by forwarding.

The block owns the control slice of the decode/execute register: the destination specifier and the load, register-write and memory-write flags. A bubble clears the three flags and leaves the destination field as it was. The execute-stage destination and load flag that the comparison uses come from this slice. All other read-after-write cases are left to forwarding and to the register file, which is written in the first half of a cycle and read in the second. A build-time option exempts a store whose only link to the load is its data register, for pipelines that forward from memory output to memory input.

Top module: `lu_interlock`

## Requirements
- R1: While reset is held and at the first cycle after it, the execute-stage flags (load, register write, memory write) and destination are all zero, both write enables read 1 and bubble reads 0.
- R2: When execute holds a load with a nonzero destination and decode uses its first source with the same specifier, pc_we and ifid_we are 0 and bubble is 1 in that same cycle.
- R3: The same stall is raised when the match is on the second source, marked used.
- R4: A source whose use flag is 0 never causes a stall, whatever its specifier.
- R5: A load whose destination is register 0 never causes a stall.
- R6: A non-load instruction in execute never causes a stall, even when its destination matches a used source.
- R7: After a cycle with bubble at 1, the execute-stage load, register-write and memory-write flags are all 0, while the execute destination takes the decode destination as usual.
- R8: A stall lasts exactly one cycle: with decode held unchanged, the next cycle shows no stall, and the held instruction's flags enter execute at the edge after that.
- R9: In a cycle without bubble, the decode destination and flags appear on the execute outputs after the next clock edge.
- R10: A consumer two instructions behind a load, with an unrelated instruction between them, does not stall.
- R11: With STORE_DATA_FWD at 0 a store stalls on a match of its data source (second source); with STORE_DATA_FWD at 1 it does not, but a match on its address source (first source) still stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | AW | Decode first source specifier |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2 | input | AW | Decode second source specifier |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_rd | input | AW | Decode destination specifier |
| id_is_load | input | 1 | Decode instruction is a load |
| id_is_store | input | 1 | Decode instruction is a store (second source is its data) |
| id_reg_write | input | 1 | Decode instruction writes the register file |
| id_mem_write | input | 1 | Decode instruction writes memory |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | A no-op enters execute at the next edge |
| ex_rd | output | AW | Execute-stage destination specifier |
| ex_is_load | output | 1 | Execute-stage load flag |
| ex_reg_write | output | 1 | Execute-stage register-write flag |
| ex_mem_write | output | 1 | Execute-stage memory-write flag |

## Verification
The hardest situation to reach is the cycle after a stall, when the consumer sits unchanged in decode while the load has moved on and a no-op fills execute. An error there would stall a second time or let the consumer through twice. The stimulus gets there by putting a load in execute, then holding the matching consumer on the decode inputs across two edges, as a frozen fetch/decode register would. The bench checks the stall, the cleared flags, the release and the consumer's late arrival in execute in turn. The store exemption needs a second instance built with the option on, fed the same stimulus, so that the two outcomes can be compared cycle by cycle.

// File: rtl/lui_pkg.sv
package lui_pkg;

  typedef struct packed {
    logic is_load;
    logic reg_write;
    logic mem_write;
  } ctl_t;

  // A bubble keeps the slot but drops every effect it could have.
  function automatic ctl_t squash(ctl_t c, logic kill);
    ctl_t r;
    r.is_load   = c.is_load   & ~kill;
    r.reg_write = c.reg_write & ~kill;
    r.mem_write = c.mem_write & ~kill;
    return r;
  endfunction

  // A source is a live consumer unless it is a store's data source and
  // memory-to-memory forwarding is present.
  function automatic logic source_live(logic used, logic is_data_src,
                                       logic is_store, logic exempt);
    return used & ~(exempt & is_data_src & is_store);
  endfunction

endpackage

// File: rtl/lui_src_match.sv
module lui_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          live,
  input  logic [AW-1:0] dest,
  input  logic          dest_is_load,
  output logic          hit
);
  logic dest_real;
  assign dest_real = (dest != '0);
  assign hit = live & dest_is_load & dest_real & (src == dest);
endmodule

// File: rtl/lui_idex_ctl.sv
module lui_idex_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic [AW-1:0] id_rd,
  input  lui_pkg::ctl_t id_ctl,
  output logic [AW-1:0] ex_rd,
  output lui_pkg::ctl_t ex_ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_rd  <= '0;
      ex_ctl <= '0;
    end else begin
      ex_rd  <= id_rd;
      ex_ctl <= lui_pkg::squash(id_ctl, kill);
    end
  end
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock #(
  parameter int AW             = 5,
  parameter bit STORE_DATA_FWD = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic          id_rs1_used,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs2_used,
  input  logic [AW-1:0] id_rd,
  input  logic          id_is_load,
  input  logic          id_is_store,
  input  logic          id_reg_write,
  input  logic          id_mem_write,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          bubble,
  output logic [AW-1:0] ex_rd,
  output logic          ex_is_load,
  output logic          ex_reg_write,
  output logic          ex_mem_write
);
  localparam int NSRC = 2;

  logic [AW-1:0] src_spec [NSRC];
  logic [NSRC-1:0] src_used;
  logic [NSRC-1:0] src_live;
  logic [NSRC-1:0] src_hit;
  logic            hit_rs1;
  logic            hit_rs2;
  logic            load_use;

  lui_pkg::ctl_t id_ctl;
  lui_pkg::ctl_t ex_ctl;

  assign src_spec[0] = id_rs1;
  assign src_spec[1] = id_rs2;
  assign src_used    = {id_rs2_used, id_rs1_used};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_live[s] = lui_pkg::source_live(src_used[s], (s == 1),
                                              id_is_store, STORE_DATA_FWD);
    lui_src_match #(.AW(AW)) u_match (
      .src          (src_spec[s]),
      .live         (src_live[s]),
      .dest         (ex_rd),
      .dest_is_load (ex_ctl.is_load),
      .hit          (src_hit[s])
    );
  end

  assign hit_rs1  = src_hit[0];
  assign hit_rs2  = src_hit[1];
  assign load_use = |src_hit;

  assign pc_we   = ~load_use;
  assign ifid_we = ~load_use;
  assign bubble  = load_use;

  assign id_ctl.is_load   = id_is_load;
  assign id_ctl.reg_write = id_reg_write;
  assign id_ctl.mem_write = id_mem_write;

  lui_idex_ctl #(.AW(AW)) u_idex (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill   (load_use),
    .id_rd  (id_rd),
    .id_ctl (id_ctl),
    .ex_rd  (ex_rd),
    .ex_ctl (ex_ctl)
  );

  assign ex_is_load   = ex_ctl.is_load;
  assign ex_reg_write = ex_ctl.reg_write;
  assign ex_mem_write = ex_ctl.mem_write;
endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs1,
  input logic          id_rs1_used,
  input logic          id_reg_write,
  input logic [AW-1:0] id_rd,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          bubble,
  input logic [AW-1:0] ex_rd,
  input logic          ex_is_load,
  input logic          ex_reg_write,
  input logic          ex_mem_write,
  input logic          hit_rs1,
  input logic          hit_rs2
);
  AST_FREEZE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifid_we) && (bubble == !pc_we)); // R2

  AST_RS1_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_rd != '0 && id_rs1_used && id_rs1 == ex_rd) |-> bubble); // R2

  AST_HIT_MEANS_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rs1 || hit_rs2) |-> bubble); // R3

  AST_ZERO_DEST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !bubble); // R5

  AST_NONLOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !bubble); // R6

  AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (!ex_is_load && !ex_reg_write && !ex_mem_write)); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble); // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble |=> (ex_reg_write == $past(id_reg_write)) && (ex_rd == $past(id_rd))); // R9
endmodule

bind lu_interlock lu_interlock_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .id_rs1       (id_rs1),
  .id_rs1_used  (id_rs1_used),
  .id_reg_write (id_reg_write),
  .id_rd        (id_rd),
  .pc_we        (pc_we),
  .ifid_we      (ifid_we),
  .bubble       (bubble),
  .ex_rd        (ex_rd),
  .ex_is_load   (ex_is_load),
  .ex_reg_write (ex_reg_write),
  .ex_mem_write (ex_mem_write),
  .hit_rs1      (hit_rs1),
  .hit_rs2      (hit_rs2)
);

// File: tb/lu_interlock_test.sv
module lu_interlock_test;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic          id_rs1_used = 1'b0, id_rs2_used = 1'b0;
  logic          id_is_load = 1'b0, id_is_store = 1'b0;
  logic          id_reg_write = 1'b0, id_mem_write = 1'b0;

  logic          pc_we, ifid_we, bubble, ex_is_load, ex_reg_write, ex_mem_write;
  logic [AW-1:0] ex_rd;
  logic          f_pc_we, f_ifid_we, f_bubble, f_ex_is_load, f_ex_reg_write, f_ex_mem_write;
  logic [AW-1:0] f_ex_rd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  lu_interlock #(.AW(AW), .STORE_DATA_FWD(1'b0)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
    .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
    .id_rd(id_rd), .id_is_load(id_is_load), .id_is_store(id_is_store),
    .id_reg_write(id_reg_write), .id_mem_write(id_mem_write),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble),
    .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .ex_reg_write(ex_reg_write), .ex_mem_write(ex_mem_write)
  );

  lu_interlock #(.AW(AW), .STORE_DATA_FWD(1'b1)) uut_fwd (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
    .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
    .id_rd(id_rd), .id_is_load(id_is_load), .id_is_store(id_is_store),
    .id_reg_write(id_reg_write), .id_mem_write(id_mem_write),
    .pc_we(f_pc_we), .ifid_we(f_ifid_we), .bubble(f_bubble),
    .ex_rd(f_ex_rd), .ex_is_load(f_ex_is_load),
    .ex_reg_write(f_ex_reg_write), .ex_mem_write(f_ex_mem_write)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_stall(input bit stall, input string req);
    check(pc_we == !stall, req, "pc_we", int'(pc_we), int'(!stall));
    check(ifid_we == !stall, req, "ifid_we", int'(ifid_we), int'(!stall));
    check(bubble == stall, req, "bubble", int'(bubble), int'(stall));
  endtask

  task automatic set_id(input int rs1, input bit u1, input int rs2, input bit u2,
                        input int rd, input bit ld, input bit st,
                        input bit rw, input bit mw);
    id_rs1 = AW'(rs1); id_rs1_used = u1;
    id_rs2 = AW'(rs2); id_rs2_used = u2;
    id_rd = AW'(rd); id_is_load = ld; id_is_store = st;
    id_reg_write = rw; id_mem_write = mw;
    #1;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue_load(input int rd);
    set_id(1, 1'b1, 0, 1'b0, rd, 1'b1, 1'b0, 1'b1, 1'b0);
    step();
    check(ex_is_load == 1'b1, "R9", "load flag in execute", int'(ex_is_load), 1);
    check(int'(ex_rd) == rd, "R9", "load dest in execute", int'(ex_rd), rd);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check(ex_is_load == 0 && ex_reg_write == 0 && ex_mem_write == 0, "R1",
          "flags in reset", int'({ex_is_load, ex_reg_write, ex_mem_write}), 0);
    check(ex_rd == '0, "R1", "dest in reset", int'(ex_rd), 0);
    expect_stall(1'b0, "R1");
    rst_n = 1'b1;
    #1;
    expect_stall(1'b0, "R1");
  endtask

  task automatic t_rs1_stall;
    issue_load(5);
    set_id(5, 1'b1, 7, 1'b1, 9, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b1, "R2");
    step();
    check(!ex_is_load && !ex_reg_write && !ex_mem_write, "R7", "bubble flags",
          int'({ex_is_load, ex_reg_write, ex_mem_write}), 0);
    check(ex_rd == AW'(9), "R7", "bubble dest", int'(ex_rd), 9);
    expect_stall(1'b0, "R8");
    step();
    check(ex_reg_write == 1'b1, "R8", "consumer enters execute", int'(ex_reg_write), 1);
    check(ex_rd == AW'(9), "R8", "consumer dest", int'(ex_rd), 9);
  endtask

  task automatic t_rs2_stall;
    issue_load(17);
    set_id(3, 1'b1, 17, 1'b1, 4, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b1, "R3");
    step();
    check(!ex_reg_write, "R7", "bubble after rs2 stall", int'(ex_reg_write), 0);
    expect_stall(1'b0, "R8");
    step();
  endtask

  task automatic t_unused;
    issue_load(6);
    set_id(6, 1'b0, 6, 1'b0, 2, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b0, "R4");
    step();
    check(ex_reg_write == 1'b1, "R4", "unused source passes", int'(ex_reg_write), 1);
  endtask

  task automatic t_zero_dest;
    issue_load(0);
    set_id(0, 1'b1, 0, 1'b1, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b0, "R5");
    step();
  endtask

  task automatic t_alu_producer;
    set_id(1, 1'b1, 2, 1'b1, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    step();
    set_id(8, 1'b1, 8, 1'b1, 11, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b0, "R6");
    step();
    check(ex_rd == AW'(11) && ex_reg_write, "R9", "alu consumer passes",
          int'(ex_rd), 11);
  endtask

  task automatic t_gap;
    issue_load(10);
    set_id(1, 1'b1, 2, 1'b1, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b0, "R10");
    step();
    set_id(10, 1'b1, 10, 1'b1, 13, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_stall(1'b0, "R10");
    step();
  endtask

  task automatic t_store;
    issue_load(12);
    set_id(4, 1'b1, 12, 1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b1);
    check(bubble == 1'b1, "R11", "data match stalls without option", int'(bubble), 1);
    check(f_bubble == 1'b0, "R11", "data match exempt with option", int'(f_bubble), 0);
    check(f_pc_we == 1'b1, "R11", "pc_we with option", int'(f_pc_we), 1);
    step();
    check(f_ex_mem_write == 1'b1, "R11", "exempt store enters execute",
          int'(f_ex_mem_write), 1);
    check(ex_mem_write == 1'b0, "R11", "stalled store bubbled", int'(ex_mem_write), 0);
    issue_load(12);
    set_id(12, 1'b1, 3, 1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b1);
    check(f_bubble == 1'b1, "R11", "address match stalls with option", int'(f_bubble), 1);
    check(bubble == 1'b1, "R11", "address match stalls without option", int'(bubble), 1);
    step();
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rs1_stall();
    t_rs2_stall();
    t_unused();
    t_zero_dest();
    t_alu_producer();
    t_gap();
    t_store();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule